// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is the command front end of a parallel NOR flash model. It watches the write cycles on the device bus and recognises the two-write unlock prefix and the command code that follows it. From these it keeps track of which read mode the device is in: normal array read, identifier (auto-select) read, or the common flash interface (CFI) query. The array storage, program and erase timing, the contents of the query table and any high-voltage pin methods sit in other blocks. This block only decides the mode and, in identifier mode, supplies the word for the read bus.

In identifier mode the low word-address bits select one of four words: the manufacturer code, the device code, the protection flag of the block named by the upper address bits, or the extended-block verify code. The extended-block verify code depends on the protection variant (top or bottom) and on the factory lock input. A byte-wide bus mode moves the unlock addresses and treats the lowest address bit as the byte select. Leaving the query mode goes back to the mode it was entered from. A query entered from identifier mode therefore needs two reset commands to reach array read.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), mode_o is 0 (array read; 1 is identifier mode, 2 is query mode), rd_drive is 0 and rd_data is 0.
- R2: In word mode (byte_mode low), the writes AA at 555h, 55 at 2AAh and 90 at 555h (low 12 address bits compared, data in wr_data) put the block in identifier mode. The mode is visible after the clock edge that takes the last write.
- R3: In byte mode (byte_mode high), the same sequence uses AAAh for the first and third writes and 555h for the second. A word-mode address in byte mode does not match.
- R4: An unlock write with a wrong address or wrong data returns the sequence tracker to idle and leaves mode_o unchanged. This includes an F0 written as the second unlock write. Without a write, mode_o never changes.
- R5: A single write of 98 at address 55h (word mode) or AAh (byte mode), from array read or identifier mode, enters query mode.
- R6: In query mode entered from array read, one write of F0 returns mode_o to 0.
- R7: In query mode entered from identifier mode, the first F0 returns mode_o to 1 and a second F0 returns it to 0.
- R8: Outside query mode, F0 returns to array read. It may be written as a single write at any address, or after the two unlock writes at the first unlock address.
- R9: In identifier mode, word offset 0 (word address bits 0-3 and 6 low, others don't care) reads the manufacturer code 0020h.
- R10: In identifier mode, word offset 1 reads the device code parameter, default 227Eh.
- R11: In identifier mode, word offset 2 reads 0001h when the block whose number is in word-address bits 23:16 has its blk_prot bit set, and 0000h otherwise.
- R12: In identifier mode, word offset 3 reads 0099h / 0019h (locked / not locked) for the top-protected variant and 0089h / 0009h for the bottom-protected variant.
- R13: rd_data is registered one cycle after rd_addr. rd_drive is 1 only in identifier mode. rd_data is 0 when rd_drive is 0, and also for offsets with word-address bit 2, 3 or 6 set. In byte mode the word address is rd_addr shifted right by one and bits 15:8 of rd_data read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_mode | input | 1 | High selects the byte-wide bus organisation |
| wr_en | input | 1 | One bus write cycle per clock when high |
| wr_addr | input | ADDR_W | Write address (byte address in byte mode) |
| wr_data | input | 8 | Command data of the write |
| rd_addr | input | ADDR_W | Read address |
| blk_prot | input | 2**BLK_W | Per-block protection flags |
| ext_locked | input | 1 | Extended block factory-lock flag |
| mode_o | output | 2 | Current read mode: 0 array, 1 identifier, 2 query |
| rd_data | output | 16 | Identifier word for the previous cycle's rd_addr |
| rd_drive | output | 1 | High when rd_data carries an identifier word |

## Verification
A command takes effect at the clock edge that accepts its final write. The bench drives every write on a falling edge and reads mode_o at the next falling edge, just after the edge that accepts the write. Identifier words lag the read address by one register. The bench therefore places rd_addr on a falling edge and samples rd_data and rd_drive one full cycle later, with no write in between, so the mode seen by the read register is settled. The random phase keeps its own model of the mode and of the return slot, and after each operation it compares both devices, top and bottom variant, against words computed from that model.

// File: rtl/nor_cmd_pkg.sv
// Shared types and command codes for the NOR flash command interpreter.
// Assumes 8-bit command data and 12-bit unlock address comparison.
package nor_cmd_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY   = 2'd0,
        MODE_AUTOSEL = 2'd1,
        MODE_CFI     = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_GOT_AA = 2'd1,
        SEQ_GOT_55 = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_AUTOSEL = 2'd1,
        ACT_CFI     = 2'd2,
        ACT_RESET   = 2'd3
    } act_e;

    localparam logic [7:0] CODE_UNLK1   = 8'hAA;
    localparam logic [7:0] CODE_UNLK2   = 8'h55;
    localparam logic [7:0] CODE_AUTOSEL = 8'h90;
    localparam logic [7:0] CODE_RESET   = 8'hF0;
    localparam logic [7:0] CODE_CFI     = 8'h98;

    localparam logic [11:0] W_UNLK1_ADDR = 12'h555;
    localparam logic [11:0] W_UNLK2_ADDR = 12'h2AA;
    localparam logic [11:0] W_CFI_ADDR   = 12'h055;
    localparam logic [11:0] B_UNLK1_ADDR = 12'hAAA;
    localparam logic [11:0] B_UNLK2_ADDR = 12'h555;
    localparam logic [11:0] B_CFI_ADDR   = 12'h0AA;
endpackage

// File: rtl/nor_seq_tracker.sv
// Unlock sequence tracker. Follows the two-write unlock prefix and turns
// the write that completes a command into a one-cycle action code.
// Assumes at most one write per clock; compares only the low 12 address bits.
module nor_seq_tracker
    import nor_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_mode,
    input  logic        wr_en,
    input  logic [11:0] wr_lo,
    input  logic [7:0]  wr_data,
    output act_e        act_o,
    output logic        idle_o
);
    seq_e        st, st_nxt;
    logic [11:0] a_unlk1, a_unlk2, a_cfi;

    // Pick the unlock and query addresses for the bus organisation
    always_comb begin
        a_unlk1 = byte_mode ? B_UNLK1_ADDR : W_UNLK1_ADDR;
        a_unlk2 = byte_mode ? B_UNLK2_ADDR : W_UNLK2_ADDR;
        a_cfi   = byte_mode ? B_CFI_ADDR   : W_CFI_ADDR;
    end

    // Next sequence state and completed-command action
    always_comb begin
        st_nxt = st;
        act_o  = ACT_NONE;
        if (wr_en) begin
            unique case (st)
                SEQ_IDLE: begin
                    if (wr_data == CODE_RESET)
                        act_o = ACT_RESET;
                    else if (wr_data == CODE_CFI && wr_lo == a_cfi)
                        act_o = ACT_CFI;
                    else if (wr_data == CODE_UNLK1 && wr_lo == a_unlk1)
                        st_nxt = SEQ_GOT_AA;
                end
                SEQ_GOT_AA: begin
                    st_nxt = (wr_data == CODE_UNLK2 && wr_lo == a_unlk2) ?
                             SEQ_GOT_55 : SEQ_IDLE;
                end
                SEQ_GOT_55: begin
                    st_nxt = SEQ_IDLE;
                    if (wr_lo == a_unlk1) begin
                        if (wr_data == CODE_AUTOSEL)
                            act_o = ACT_AUTOSEL;
                        else if (wr_data == CODE_RESET)
                            act_o = ACT_RESET;
                    end
                end
                default: st_nxt = SEQ_IDLE;
            endcase
        end
    end

    // Sequence state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEQ_IDLE;
        else        st <= st_nxt;
    end

    assign idle_o = (st == SEQ_IDLE);
endmodule

// File: rtl/nor_mode_ctrl.sv
// Read mode register. Applies action codes and keeps the mode that the
// query mode was entered from, so a reset in query mode returns there.
// Assumes at most one action per clock.
module nor_mode_ctrl
    import nor_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  act_e     act_i,
    output rd_mode_e mode_o
);
    rd_mode_e ret_mode;

    // Mode and return-slot update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o   <= MODE_ARRAY;
            ret_mode <= MODE_ARRAY;
        end else begin
            unique case (act_i)
                ACT_AUTOSEL: if (mode_o != MODE_CFI) mode_o <= MODE_AUTOSEL;
                ACT_CFI: begin
                    if (mode_o != MODE_CFI) begin
                        ret_mode <= mode_o;
                        mode_o   <= MODE_CFI;
                    end
                end
                ACT_RESET: mode_o <= (mode_o == MODE_CFI) ? ret_mode : MODE_ARRAY;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nor_ident_mux.sv
// Identifier read path. In identifier mode, decodes the word offset from
// the read address and registers the matching word. Otherwise it registers zero.
// Assumes word-address bits 0..3 and 6 select, and the block number sits in the top BLK_W bits.
module nor_ident_mux
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 25,
    parameter int          BLK_W       = 8,
    parameter logic [15:0] MFR_ID      = 16'h0020,
    parameter logic [15:0] DEV_ID      = 16'h227E,
    parameter bit          TOP_VARIANT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_mode,
    input  rd_mode_e              mode_i,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [(1<<BLK_W)-1:0] blk_prot,
    input  logic                  ext_locked,
    output logic [15:0]           rd_data,
    output logic                  rd_drive
);
    localparam int WA_W = ADDR_W - 1;
    localparam logic [1:0][15:0] ID_TAB = {DEV_ID, MFR_ID};

    logic [WA_W-1:0]  wa;
    logic [BLK_W-1:0] blk_idx;
    logic [7:0]       ext_code;
    logic             sel_ok;
    logic [15:0]      word_nxt;
    logic             unused_bits;

    // Word address for the bus organisation
    assign wa      = byte_mode ? rd_addr[ADDR_W-1:1] : rd_addr[WA_W-1:0];
    assign blk_idx = wa[WA_W-1 -: BLK_W];
    assign sel_ok  = !wa[6] && !wa[3] && !wa[2];
    assign unused_bits = ^{wa[5:4], wa[WA_W-BLK_W-1:7]};

    // Extended-block verify code for the protection variant
    generate
        if (TOP_VARIANT) begin : g_top
            assign ext_code = ext_locked ? 8'h99 : 8'h19;
        end else begin : g_bot
            assign ext_code = ext_locked ? 8'h89 : 8'h09;
        end
    endgenerate

    // Select the identifier word for the decoded offset
    always_comb begin
        word_nxt = '0;
        if (sel_ok) begin
            unique case (wa[1:0])
                2'd0, 2'd1: word_nxt = ID_TAB[wa[0]];
                2'd2:       word_nxt = {15'd0, blk_prot[blk_idx]};
                default:    word_nxt = {8'd0, ext_code};
            endcase
        end
        if (byte_mode) word_nxt[15:8] = 8'd0;
    end

    // Output register for the read bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_drive <= 1'b0;
        end else if (mode_i == MODE_AUTOSEL) begin
            rd_data  <= word_nxt;
            rd_drive <= 1'b1;
        end else begin
            rd_data  <= '0;
            rd_drive <= 1'b0;
        end
    end
endmodule

// File: rtl/nor_cmd_decoder.sv
// Top of the NOR flash command interpreter. Connects the unlock tracker,
// the mode register and the identifier read path.
// Assumes the caller presents one bus write per clock on wr_en.
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 25,
    parameter int          BLK_W       = 8,
    parameter logic [15:0] MFR_ID      = 16'h0020,
    parameter logic [15:0] DEV_ID      = 16'h227E,
    parameter bit          TOP_VARIANT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_mode,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [(1<<BLK_W)-1:0] blk_prot,
    input  logic                  ext_locked,
    output logic [1:0]            mode_o,
    output logic [15:0]           rd_data,
    output logic                  rd_drive
);
    act_e     act;
    rd_mode_e mode;
    logic     seq_idle;
    logic     unused_wr_hi;

    assign unused_wr_hi = ^wr_addr[ADDR_W-1:12];

    nor_seq_tracker u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_mode(byte_mode),
        .wr_en   (wr_en),
        .wr_lo   (wr_addr[11:0]),
        .wr_data (wr_data),
        .act_o   (act),
        .idle_o  (seq_idle)
    );

    nor_mode_ctrl u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .mode_o(mode)
    );

    nor_ident_mux #(
        .ADDR_W     (ADDR_W),
        .BLK_W      (BLK_W),
        .MFR_ID     (MFR_ID),
        .DEV_ID     (DEV_ID),
        .TOP_VARIANT(TOP_VARIANT)
    ) u_ident (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .mode_i    (mode),
        .rd_addr   (rd_addr),
        .blk_prot  (blk_prot),
        .ext_locked(ext_locked),
        .rd_data   (rd_data),
        .rd_drive  (rd_drive)
    );

    assign mode_o = mode;
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
// Property checker for the command interpreter, attached through bind.
// Assumes the mode encoding and command codes from nor_cmd_pkg.
module nor_cmd_decoder_chk
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_mode,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [1:0]        mode_o,
    input logic [15:0]       rd_data,
    input logic              rd_drive,
    input logic              seq_idle
);
    // R1: reset leaves array read with a quiet read bus
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 2'd0 && !rd_drive && rd_data == 16'd0));

    // R4: the mode only moves on a write cycle
    a_r4_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_o));

    // R5: a query entry write from idle enters query mode
    a_r5_cfi_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && wr_en && wr_data == CODE_CFI &&
         wr_addr[11:0] == (byte_mode ? B_CFI_ADDR : W_CFI_ADDR)) |=> mode_o == 2'd2);

    // R6 and R7: a reset write in query mode always leaves query mode
    a_r6_cfi_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && wr_en && wr_data == CODE_RESET && mode_o == 2'd2) |=> mode_o != 2'd2);

    // R8: a reset write outside query mode lands in array read
    a_r8_reset_to_array: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && wr_en && wr_data == CODE_RESET && mode_o != 2'd2) |=> mode_o == 2'd0);

    // R13: no identifier data unless the bus is driven
    a_r13_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> rd_data == 16'd0);

    // R13: the bus is driven only after a cycle in identifier mode
    a_r13_drive_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> $past(mode_o) == 2'd1);
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_mode(byte_mode),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode_o   (mode_o),
    .rd_data  (rd_data),
    .rd_drive (rd_drive),
    .seq_idle (seq_idle)
);

// File: tb/sim_nor_cmd_decoder.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random operations
// compared against a bench-side model of the mode and identifier words.
module sim_nor_cmd_decoder;
    localparam int ADDR_W = 25;
    localparam int BLK_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              byte_mode = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [255:0]      blk_prot = '0;
    logic              ext_locked = 1'b0;
    logic [1:0]        mode0, mode1;
    logic [15:0]       rdata0, rdata1;
    logic              drv0, drv1;

    int n_tests = 0;
    int n_fail  = 0;
    logic [1:0] m_mode = 2'd0;
    logic [1:0] m_ret  = 2'd0;

    always #2 clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .TOP_VARIANT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .blk_prot(blk_prot), .ext_locked(ext_locked),
        .mode_o(mode0), .rd_data(rdata0), .rd_drive(drv0));

    nor_cmd_decoder #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .TOP_VARIANT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .blk_prot(blk_prot), .ext_locked(ext_locked),
        .mode_o(mode1), .rd_data(rdata1), .rd_drive(drv1));

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #600000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got hang exp finish");
        finish_run();
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [ADDR_W-1:0] a, input logic bm,
                                             input logic [1:0] md, input logic top);
        logic [23:0] wa;
        logic [15:0] v;
        wa = bm ? a[24:1] : a[23:0];
        v = 16'h0000;
        if (md == 2'd1 && !wa[6] && !wa[3] && !wa[2]) begin
            case (wa[1:0])
                2'd0: v = 16'h0020;
                2'd1: v = 16'h227E;
                2'd2: v = {15'd0, blk_prot[wa[23:16]]};
                default: v = top ? (ext_locked ? 16'h0099 : 16'h0019)
                                 : (ext_locked ? 16'h0089 : 16'h0009);
            endcase
        end
        if (bm) v[15:8] = 8'h00;
        return v;
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
    endtask

    function automatic logic [11:0] ua1(); return byte_mode ? 12'hAAA : 12'h555; endfunction
    function automatic logic [11:0] ua2(); return byte_mode ? 12'h555 : 12'h2AA; endfunction
    function automatic logic [11:0] uacfi(); return byte_mode ? 12'h0AA : 12'h055; endfunction

    task automatic op_autosel();
        wr({13'd0, ua1()}, 8'hAA); wr({13'd0, ua2()}, 8'h55); wr({13'd0, ua1()}, 8'h90);
        if (m_mode != 2'd2) m_mode = 2'd1;
    endtask
    task automatic op_cfi();
        wr({13'd0, uacfi()}, 8'h98);
        if (m_mode != 2'd2) begin m_ret = m_mode; m_mode = 2'd2; end
    endtask
    task automatic op_reset();
        wr({$urandom} % 25'h1FFFFFF, 8'hF0);
        m_mode = (m_mode == 2'd2) ? m_ret : 2'd0;
    endtask
    task automatic op_abort();
        wr({13'd0, ua1()}, 8'hAA); wr({13'd0, ua2()}, 8'h55); wr({13'd0, ua1()}, 8'hF0);
        m_mode = (m_mode == 2'd2) ? m_ret : 2'd0;
    endtask

    task automatic chk_read(input string tag, input logic [ADDR_W-1:0] a);
        rd(a);
        chk({tag, " u0 data"}, rdata0, exp_word(a, byte_mode, m_mode, 1'b1));
        chk({tag, " u1 data"}, rdata1, exp_word(a, byte_mode, m_mode, 1'b0));
        chk({tag, " drive"}, {15'd0, drv0}, {15'd0, m_mode == 2'd1});
    endtask

    task automatic chk_mode(input string tag);
        chk({tag, " mode u0"}, {14'd0, mode0}, {14'd0, m_mode});
        chk({tag, " mode u1"}, {14'd0, mode1}, {14'd0, m_mode});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        blk_prot = '0;
        blk_prot[5] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 mode", {14'd0, mode0}, 16'd0);
        chk("R1 data", rdata0, 16'd0);
        chk("R1 drive", {15'd0, drv0}, 16'd0);
        // R13: array read keeps bus quiet
        chk_read("R13 array", 25'd0);
        // R2: word-mode identifier entry
        op_autosel(); chk_mode("R2 entry");
        chk_read("R9 manufacturer", 25'h000000);
        chk_read("R9 upper bits ignored", 25'h000130);
        chk_read("R10 device", 25'h000001);
        chk_read("R11 protected block", {1'b0, 8'd5, 16'h0002});
        chk_read("R11 open block", {1'b0, 8'd6, 16'h0002});
        ext_locked = 1'b1;
        chk_read("R12 locked", 25'h000003);
        ext_locked = 1'b0;
        chk_read("R12 open", 25'h000003);
        chk_read("R13 offset A6", 25'h000040);
        chk_read("R13 offset A2", 25'h000004);
        // R4: bad unlock with F0 as second write keeps identifier mode
        wr(25'h555, 8'hAA); wr(25'h2AA, 8'hF0); chk_mode("R4 f0 as second");
        // R8: single F0
        op_reset(); chk_mode("R8 single reset");
        // R4: wrong address then a command code
        wr(25'h555, 8'hAA); wr(25'h2AB, 8'h55); wr(25'h555, 8'h90); chk_mode("R4 bad addr");
        wr(25'h555, 8'hAA); wr(25'h2AA, 8'h56); wr(25'h555, 8'h90); chk_mode("R4 bad data");
        // R5 and R6: query from array read
        op_cfi(); chk_mode("R5 entry");
        chk_read("R13 query quiet", 25'd0);
        op_reset(); chk_mode("R6 one reset");
        // R7: query from identifier mode needs two resets
        op_autosel(); op_cfi(); chk_mode("R7 entry");
        op_reset(); chk_mode("R7 first reset");
        op_reset(); chk_mode("R7 second reset");
        // R8: three-write abort sequence
        op_autosel(); op_abort(); chk_mode("R8 abort");
        // R3: byte mode addresses
        byte_mode = 1'b1;
        wr(25'h555, 8'hAA); wr(25'h2AA, 8'h55); wr(25'h555, 8'h90); chk_mode("R3 word addr rejected");
        op_autosel(); chk_mode("R3 entry");
        chk_read("R3 R10 byte device", 25'h000002);
        chk_read("R3 R11 byte protect", {8'd5, 17'h00004});
        chk_read("R3 R9 byte manufacturer", 25'h000001);
        op_cfi(); chk_mode("R3 R5 byte query");
        op_reset(); op_reset(); chk_mode("R3 R7 byte exit");
        // Random phase
        for (int i = 0; i < 400; i++) begin
            int sel;
            byte_mode = $urandom_range(0, 1);
            ext_locked = $urandom_range(0, 1);
            blk_prot[$urandom_range(0, 255)] = $urandom_range(0, 1);
            sel = $urandom_range(0, 7);
            case (sel)
                0: op_autosel();
                1: op_cfi();
                2: op_reset();
                3: op_abort();
                4: begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    if (d == 8'hAA || d == 8'hF0 || d == 8'h98) d = 8'h12;
                    wr(25'($urandom), d);
                end
                default: begin
                    logic [ADDR_W-1:0] a;
                    a = {8'($urandom), 10'($urandom), 7'($urandom_range(0, 8))};
                    if (sel == 7) a[6] = 1'b1;
                    chk_read("R9 R10 R11 R12 R13 random", a);
                end
            endcase
            chk_mode("R2 R4 R6 R7 R8 random");
        end
        finish_run();
    end
endmodule